// File: doc/BRIEF.md
# Converted Index Address Generator

This block maps the element index of an array of packed floating-point values onto a displacement counted in 12-bit units. The storage layout it serves places three 60-bit elements or five 36-bit elements in each 192-bit memory line. Each line has sixteen 12-bit units, and the last unit of every line stays empty. Arrays are cut into fixed blocks: 32 wide elements fill 11 lines, and 64 narrow elements fill 13 lines. Inside each block, one line slot goes unused.

Because of this layout, no divider is needed. The index bits above the block boundary are multiplied by a constant line stride: 176 units for 60-bit elements and 208 units for 36-bit elements. The low index bits go to a small constant table. That table returns the line inside the block, weighted by 16, plus the slot inside the line, weighted by the element size in units. The sum of the two parts is registered, together with a matching valid flag.

The result is also given as a line number and a unit offset within the line. The caller adds the array base and performs the memory access; both are outside this block.

Top module: `cx_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid input, `out_valid` is 0 and `out_disp` is 0.
- R2: `out_valid` is 1 in exactly the cycle that follows a cycle with `in_valid` = 1, and 0 otherwise.
- R3: With `in_wide` = 1 (60-bit elements), `out_disp` = floor(i/32)*176 + floor((i mod 32)/3)*16 + ((i mod 32) mod 3)*5, where i is the captured index.
- R4: With `in_wide` = 0 (36-bit elements), `out_disp` = floor(i/64)*208 + floor((i mod 64)/5)*16 + ((i mod 64) mod 5)*3.
- R5: `out_line` equals `out_disp` divided by 16, and `out_unit` equals `out_disp` mod 16.
- R6: An element never crosses a line boundary. `out_unit` plus the element size (5 units when wide, 3 units when narrow) is at most 15.
- R7: In a cycle with `in_valid` = 0, the next cycle's `out_disp`, `out_line` and `out_unit` keep their previous values.
- R8: Every index in the full `IDX_W`-bit range, including all ones, converts without truncation in both modes.
- R9: A new index may be presented in every cycle, and the precision may change from one cycle to the next. Each result depends only on its own index and precision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Index strobe |
| in_index | input | IDX_W (36) | Unsigned element index |
| in_wide | input | 1 | 1 = 60-bit elements, 0 = 36-bit elements |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_disp | output | IDX_W+3 (39) | Displacement in 12-bit units |
| out_line | output | IDX_W-1 (35) | Line number (displacement / 16) |
| out_unit | output | 4 | Unit offset within the line |

## Verification
A wrong table entry corrupts only the indices that share its low bits. The error appears one cycle later, either as a wrong `out_unit` or as a line number off by a few lines. For this reason every residue of both table widths is swept, across several blocks. A wrong stride multiplier shows up as a growing error from the second block onward, and large indices expose a truncated upper product at once. A stale precision or capture register shows in the cycle after a mode switch or an idle cycle, so streams that switch mode every cycle and idle gaps are both compared against a reference that uses true division.

// File: rtl/cx_pkg.sv
package cx_pkg;
   localparam int UNITS_PER_LINE = 16;
   localparam int LINE_SHIFT     = 4;

   // Offset (in 12-bit units) of slot k inside a block: line-in-block
   // weighted by a full line, plus slot-in-line weighted by element size.
   function automatic int slot_offset(int k, int per_line, int elem_units);
      return (k / per_line) * UNITS_PER_LINE + (k % per_line) * elem_units;
   endfunction
endpackage

// File: rtl/cx_low_lut.sv
module cx_low_lut #(
   parameter int LOW_BITS   = 5,
   parameter int PER_LINE   = 3,
   parameter int ELEM_UNITS = 5,
   parameter int OFF_W      = 8
) (
   input  logic [LOW_BITS-1:0] low_idx,
   output logic [OFF_W-1:0]    offset
);
   localparam int DEPTH = 1 << LOW_BITS;

   logic [OFF_W-1:0] table_w [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_entry
         assign table_w[g] = OFF_W'(cx_pkg::slot_offset(g, PER_LINE, ELEM_UNITS));
      end
   endgenerate

   assign offset = table_w[low_idx];
endmodule

// File: rtl/cx_stride_mul.sv
module cx_stride_mul #(
   parameter int IN_W   = 31,
   parameter int FACTOR = 11,
   parameter int OUT_W  = 35
) (
   input  logic [IN_W-1:0]  blk,
   output logic [OUT_W-1:0] prod
);
   localparam int FBITS = $clog2(FACTOR + 1);

   logic [OUT_W-1:0] term [FBITS];

   generate
      for (genvar g = 0; g < FBITS; g++) begin : g_term
         if (((FACTOR >> g) & 1) == 1) begin : g_on
            assign term[g] = OUT_W'(blk) << g;
         end else begin : g_off
            assign term[g] = '0;
         end
      end
   endgenerate

   always_comb begin
      prod = '0;
      for (int t = 0; t < FBITS; t++) prod = prod + term[t];
   end
endmodule

// File: rtl/cx_addr_gen.sv
module cx_addr_gen #(
   parameter int IDX_W         = 36,
   parameter int WIDE_LOW_BITS = 5,
   parameter int WIDE_PER_LINE = 3,
   parameter int WIDE_UNITS    = 5,
   parameter int WIDE_LINES    = 11,
   parameter int NARR_LOW_BITS = 6,
   parameter int NARR_PER_LINE = 5,
   parameter int NARR_UNITS    = 3,
   parameter int NARR_LINES    = 13,
   localparam int DISP_W       = IDX_W + 3,
   localparam int LINE_W       = DISP_W - cx_pkg::LINE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IDX_W-1:0]  in_index,
   input  logic              in_wide,
   output logic              out_valid,
   output logic [DISP_W-1:0] out_disp,
   output logic [LINE_W-1:0] out_line,
   output logic [3:0]        out_unit
);
   localparam int OFF_W    = 8;
   localparam int WBLK_W   = IDX_W - WIDE_LOW_BITS;
   localparam int NBLK_W   = IDX_W - NARR_LOW_BITS;

   generate
      if (IDX_W < 8) begin : g_chk_w
         $error("IDX_W too small");
      end
      if (WIDE_PER_LINE * WIDE_UNITS > cx_pkg::UNITS_PER_LINE - 1 ||
          NARR_PER_LINE * NARR_UNITS > cx_pkg::UNITS_PER_LINE - 1) begin : g_chk_fit
         $error("elements overflow a line");
      end
      if (WIDE_LINES * WIDE_PER_LINE < (1 << WIDE_LOW_BITS) ||
          NARR_LINES * NARR_PER_LINE < (1 << NARR_LOW_BITS)) begin : g_chk_blk
         $error("block too short for its slots");
      end
      if (WIDE_LINES > 15 || NARR_LINES > 15) begin : g_chk_stride
         $error("line stride exceeds displacement width");
      end
   endgenerate

   logic [OFF_W-1:0]  off_w, off_n;
   logic [LINE_W-1:0] prod_w, prod_n;
   logic [DISP_W-1:0] disp_w, disp_n, disp_d;

   cx_low_lut #(.LOW_BITS(WIDE_LOW_BITS), .PER_LINE(WIDE_PER_LINE),
                .ELEM_UNITS(WIDE_UNITS), .OFF_W(OFF_W)) u_lut_wide (
      .low_idx(in_index[WIDE_LOW_BITS-1:0]), .offset(off_w));

   cx_low_lut #(.LOW_BITS(NARR_LOW_BITS), .PER_LINE(NARR_PER_LINE),
                .ELEM_UNITS(NARR_UNITS), .OFF_W(OFF_W)) u_lut_narr (
      .low_idx(in_index[NARR_LOW_BITS-1:0]), .offset(off_n));

   cx_stride_mul #(.IN_W(WBLK_W), .FACTOR(WIDE_LINES), .OUT_W(LINE_W)) u_mul_wide (
      .blk(in_index[IDX_W-1:WIDE_LOW_BITS]), .prod(prod_w));

   cx_stride_mul #(.IN_W(NBLK_W), .FACTOR(NARR_LINES), .OUT_W(LINE_W)) u_mul_narr (
      .blk(in_index[IDX_W-1:NARR_LOW_BITS]), .prod(prod_n));

   assign disp_w = {prod_w, 4'b0000} + DISP_W'(off_w);
   assign disp_n = {prod_n, 4'b0000} + DISP_W'(off_n);
   assign disp_d = in_wide ? disp_w : disp_n;

   logic wide_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_disp  <= '0;
         wide_q    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_disp <= disp_d;
            wide_q   <= in_wide;
         end
      end
   end

   assign out_line = out_disp[DISP_W-1:cx_pkg::LINE_SHIFT];
   assign out_unit = out_disp[3:0];

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R2
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_disp)); // R7
   AST_NO_STRADDLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ({1'b0, out_unit} + (wide_q ? 5'(WIDE_UNITS) : 5'(NARR_UNITS))) <= 5'd15); // R6
   AST_WIDE_BLOCK_START: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_wide && in_index[WIDE_LOW_BITS-1:0] == '0) |=> out_unit == 4'd0); // R3
   AST_NARR_BLOCK_START: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_wide && in_index[NARR_LOW_BITS-1:0] == '0) |=> out_unit == 4'd0); // R4
endmodule

// File: tb/cx_addr_gen_tb.sv
module cx_addr_gen_tb_top;
   localparam int IDX_W  = 36;
   localparam int DISP_W = IDX_W + 3;
   localparam int LINE_W = DISP_W - 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [IDX_W-1:0]  in_index = '0;
   logic              in_wide = 1'b0;
   logic              out_valid;
   logic [DISP_W-1:0] out_disp;
   logic [LINE_W-1:0] out_line;
   logic [3:0]        out_unit;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   cx_addr_gen #(.IDX_W(IDX_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_index(in_index),
      .in_wide(in_wide), .out_valid(out_valid), .out_disp(out_disp),
      .out_line(out_line), .out_unit(out_unit));

   function automatic longint unsigned ref_disp(longint unsigned i, bit wide);
      longint unsigned k;
      if (wide) begin
         k = i % 32;
         return (i / 32) * 176 + (k / 3) * 16 + (k % 3) * 5;
      end
      k = i % 64;
      return (i / 64) * 208 + (k / 5) * 16 + (k % 5) * 3;
   endfunction

   task automatic chk(string req, longint unsigned act, longint unsigned exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Full check of one result already visible at the outputs.
   task automatic chk_result(longint unsigned idx, bit wide);
      longint unsigned e;
      e = ref_disp(idx, wide);
      chk(wide ? "R3" : "R4", 64'(out_disp), e);
      chk("R5_line", 64'(out_line), e / 16);
      chk("R5_unit", 64'(out_unit), e % 16);
      chk("R6", 64'((64'(out_unit) + (wide ? 5 : 3)) <= 15), 1);
      chk("R2", 64'(out_valid), 1);
   endtask

   task automatic convert_one(longint unsigned idx, bit wide);
      in_valid = 1'b1;
      in_index = IDX_W'(idx);
      in_wide  = wide;
      @(negedge clk);
      in_valid = 1'b0;
      chk_result(idx, wide);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1_valid", 64'(out_valid), 0);
      chk("R1_disp", 64'(out_disp), 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1_valid", 64'(out_valid), 0);
      chk("R1_disp", 64'(out_disp), 0);
   endtask

   task automatic t_sweep(bit wide);
      for (int i = 0; i < 200; i++) convert_one(longint'(i), wide);
   endtask

   task automatic t_large();
      longint unsigned top;
      top = (64'd1 << IDX_W) - 1;
      convert_one(top, 1'b1);   // R8
      convert_one(top, 1'b0);   // R8
      convert_one(top - 37, 1'b1);
      convert_one(top - 71, 1'b0);
      for (int s = 0; s < 40; s++) begin
         longint unsigned v;
         v = (longint'(s) * 64'h9E3779B97F4A7C15) & top;
         convert_one(v, s[0]); // R8
      end
   endtask

   task automatic t_hold();
      longint unsigned e;
      convert_one(64'd12345, 1'b1);
      e = ref_disp(64'd12345, 1'b1);
      in_index = IDX_W'(64'd999);
      in_wide  = 1'b0;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk("R7_disp", 64'(out_disp), e);
         chk("R7_unit", 64'(out_unit), e % 16);
         chk("R2_idle", 64'(out_valid), 0);
      end
   endtask

   task automatic t_stream();
      longint unsigned prev_i;
      bit prev_w;
      for (int n = 0; n < 60; n++) begin
         longint unsigned v;
         bit w;
         v = longint'(n) * 97 + 5;
         w = n[0];
         in_valid = 1'b1;
         in_index = IDX_W'(v);
         in_wide  = w;
         @(negedge clk);
         chk_result(v, w); // R9
         prev_i = v;
         prev_w = w;
      end
      in_valid = 1'b0;
      @(negedge clk);
      chk("R9_end", 64'(out_valid), 0);
      chk("R9_hold", 64'(out_disp), ref_disp(prev_i, prev_w));
   endtask

   initial begin
      t_reset();
      t_sweep(1'b1);
      t_sweep(1'b0);
      t_large();
      t_hold();
      t_stream();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule